// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Command Front End

This block is the serial front end of a small three-wire EEPROM model. It samples the chip select, serial clock and serial data input pins with a fast system clock and waits for a start bit. After the start bit it collects a two-bit opcode, an address field and, for write-type instructions, a data word. It then either hands a decoded programming or enable command to a separate cycle controller, or serves a read from an external register file.

The address field width follows an organisation input. In 8-bit word mode the field is one bit wider than in 16-bit word mode. Reads put a single zero bit on the output before the word. While chip select stays high, reads carry on through consecutive addresses. The serial output has its own enable, so it can sit at high impedance. When chip select is raised again after a programming command, the output reports ready or busy status taken from the cycle controller.

Top module: `mw_serial_front`

## Requirements
- R1: No frame begins until a rising serial clock edge samples chip select high and data-in high. Clock edges taken with data-in low, and any data-in toggling without clock edges, produce no command and leave do_oe low.
- R2: After the start bit, the 2-bit opcode is taken MSB first. Opcode 10 is a read, 01 is a write (cmd_kind 0) and 11 is an erase (cmd_kind 1). The address and data fields are taken MSB first, and cmd_addr and cmd_data hold the received fields.
- R3: For opcode 00, the two top bits of the address field select the command: 11 gives enable (cmd_kind 4), 10 gives erase-all (cmd_kind 2), 01 gives write-all (cmd_kind 3, which takes a data word) and 00 gives disable (cmd_kind 5). The lower address bits are passed through unchanged.
- R4: With org_x16 = 1 the address field has A16 bits and words are 16 bits wide, and the top bit of cmd_addr is 0. With org_x16 = 0 the field has A16+1 bits and words are 8 bits wide, taken from mem_rdata[7:0]. With A16 = 6, a 16-bit read frame needs 25 clocks and an 8-bit read frame needs 18.
- R5: On a read, the edge that takes the last address bit drives do_pin to 0 with do_oe high. The following edges drive the addressed word, MSB first, one bit per edge.
- R6: While chip select stays high after a read word, the address advances by one and the next word follows at once. The last address wraps to 0.
- R7: A command pulses cmd_valid for one system cycle, and only on the edge that takes its final bit. A frame cut short by chip select going low issues nothing. Clock edges after a complete non-read frame are ignored until chip select goes low again.
- R8: Chip select low returns the frame logic to waiting for a start bit and drives do_oe low.
- R9: After a write, write-all, erase or erase-all command, once chip select is high again and before the next start bit, do_oe is high and do_pin equals the inverse of ctl_busy. The start bit of the next frame removes the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| org_x16 | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| cs_pin | input | 1 | Serial chip select, asynchronous |
| sclk_pin | input | 1 | Serial clock, asynchronous |
| di_pin | input | 1 | Serial data in, asynchronous |
| ctl_busy | input | 1 | Cycle controller busy flag |
| mem_rdata | input | 16 | Register file read data at mem_addr |
| do_pin | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for do_pin; 0 means high impedance |
| mem_addr | output | A16+1 | Register file read address |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 3 | Command code (0 write, 1 erase, 2 erase-all, 3 write-all, 4 enable, 5 disable) |
| cmd_addr | output | A16+1 | Address field of the command |
| cmd_data | output | 16 | Data word of the command |

## Verification
A wrong bit counter or a wrong organisation width shows at the ports within one frame. The read word then starts on the wrong edge, or the command strobe appears one edge early or late, or not at all. A wrong address register shows on the first read word of a sweep across every address. A wrap fault shows one word after the last address. A state that fails to return to waiting on chip select low, or that fails to ignore trailing clocks, shows as an extra strobe or a stuck output enable during the next deselect or the next trailing-clock burst.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        CMD_WRITE = 3'd0,
        CMD_ERASE = 3'd1,
        CMD_ERAL  = 3'd2,
        CMD_WRAL  = 3'd3,
        CMD_EWEN  = 3'd4,
        CMD_EWDS  = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADR,
        ST_DAT,
        ST_RD,
        ST_DONE
    } st_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/mw_rise.sv
module mw_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/mw_serial_front.sv
module mw_serial_front #(
    parameter int A16 = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           org_x16,
    input  logic           cs_pin,
    input  logic           sclk_pin,
    input  logic           di_pin,
    input  logic           ctl_busy,
    input  logic [15:0]    mem_rdata,
    output logic           do_pin,
    output logic           do_oe,
    output logic [A16:0]   mem_addr,
    output logic           cmd_valid,
    output logic [2:0]     cmd_kind,
    output logic [A16:0]   cmd_addr,
    output logic [15:0]    cmd_data
);
    import mw_pkg::*;

    localparam int AW   = A16 + 1;
    localparam int DW   = 16;
    localparam int CNTW = $clog2(DW + AW + 1);
    localparam logic [CNTW-1:0] AW16_C = CNTW'(A16);
    localparam logic [CNTW-1:0] AW8_C  = CNTW'(AW);
    localparam logic [CNTW-1:0] DW16_C = CNTW'(DW);
    localparam logic [CNTW-1:0] DW8_C  = CNTW'(DW / 2);
    localparam logic [AW-1:0]   MASK16 = {1'b0, {A16{1'b1}}};

    typedef struct packed {
        st_e             st;
        logic [1:0]      opc;
        logic [AW-1:0]   adr;
        logic [DW-1:0]   dat;
        logic [CNTW-1:0] cnt;
        logic            dout;
        logic            doe;
        logic            stat_pend;
        logic            cv;
        cmd_e            ck;
        logic [AW-1:0]   ca;
        logic [DW-1:0]   cd;
    } regs_t;

    logic cs_s, sclk_s, di_s, edge_s;
    regs_t q, n;

    mw_sync #(.W(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_pin, sclk_pin, di_pin}),
        .sync_out ({cs_s, sclk_s, di_s})
    );

    mw_rise u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sclk_s),
        .rise  (edge_s)
    );

    logic [CNTW-1:0] aw_cur, dw_cur, idx;
    logic [AW-1:0]   mask, adr_in, adr_inc;
    logic [1:0]      sub;
    logic [DW-1:0]   word;

    always_comb begin
        mask    = org_x16 ? MASK16 : {AW{1'b1}};
        aw_cur  = org_x16 ? AW16_C : AW8_C;
        dw_cur  = org_x16 ? DW16_C : DW8_C;
        adr_in  = {q.adr[AW-2:0], di_s} & mask;
        adr_inc = (q.adr + 1'b1) & mask;
        sub     = org_x16 ? adr_in[A16-1 -: 2] : adr_in[AW-1 -: 2];
        word    = org_x16 ? mem_rdata : {8'h00, mem_rdata[7:0]};
        idx     = dw_cur - 1'b1 - q.cnt;

        n    = q;
        n.cv = 1'b0;

        if (!cs_s) begin
            n.st   = ST_IDLE;
            n.cnt  = '0;
            n.adr  = '0;
            n.doe  = 1'b0;
            n.dout = 1'b0;
        end else begin
            if (q.st == ST_IDLE && q.stat_pend) begin
                n.doe  = 1'b1;
                n.dout = ~ctl_busy;
            end
            if (edge_s) begin
                unique case (q.st)
                    ST_IDLE: if (di_s) begin
                        n.st        = ST_OPC;
                        n.cnt       = '0;
                        n.opc       = '0;
                        n.adr       = '0;
                        n.dat       = '0;
                        n.stat_pend = 1'b0;
                        n.doe       = 1'b0;
                    end
                    ST_OPC: begin
                        n.opc = {q.opc[0], di_s};
                        if (q.cnt == 1) begin
                            n.st  = ST_ADR;
                            n.cnt = '0;
                        end else begin
                            n.cnt = q.cnt + 1'b1;
                        end
                    end
                    ST_ADR: begin
                        n.adr = adr_in;
                        if (q.cnt == aw_cur - 1'b1) begin
                            n.cnt = '0;
                            n.ca  = adr_in;
                            n.st  = ST_DONE;
                            unique case (q.opc)
                                2'b10: begin
                                    n.st   = ST_RD;
                                    n.doe  = 1'b1;
                                    n.dout = 1'b0;
                                end
                                2'b01: begin
                                    n.st = ST_DAT;
                                    n.ck = CMD_WRITE;
                                end
                                2'b11: begin
                                    n.ck        = CMD_ERASE;
                                    n.cv        = 1'b1;
                                    n.stat_pend = 1'b1;
                                end
                                default: begin
                                    unique case (sub)
                                        2'b11: begin
                                            n.ck = CMD_EWEN;
                                            n.cv = 1'b1;
                                        end
                                        2'b10: begin
                                            n.ck        = CMD_ERAL;
                                            n.cv        = 1'b1;
                                            n.stat_pend = 1'b1;
                                        end
                                        2'b01: begin
                                            n.ck = CMD_WRAL;
                                            n.st = ST_DAT;
                                        end
                                        default: begin
                                            n.ck = CMD_EWDS;
                                            n.cv = 1'b1;
                                        end
                                    endcase
                                end
                            endcase
                        end else begin
                            n.cnt = q.cnt + 1'b1;
                        end
                    end
                    ST_DAT: begin
                        n.dat = {q.dat[DW-2:0], di_s};
                        if (q.cnt == dw_cur - 1'b1) begin
                            n.cd        = {q.dat[DW-2:0], di_s};
                            n.cv        = 1'b1;
                            n.stat_pend = 1'b1;
                            n.st        = ST_DONE;
                            n.cnt       = '0;
                        end else begin
                            n.cnt = q.cnt + 1'b1;
                        end
                    end
                    ST_RD: begin
                        n.dout = word[idx];
                        if (q.cnt == dw_cur - 1'b1) begin
                            n.cnt = '0;
                            n.adr = adr_inc;
                        end else begin
                            n.cnt = q.cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign do_pin    = q.dout;
    assign do_oe     = q.doe;
    assign mem_addr  = q.adr;
    assign cmd_valid = q.cv;
    assign cmd_kind  = q.ck;
    assign cmd_addr  = q.ca;
    assign cmd_data  = q.cd;
endmodule

// File: rtl/mw_front_chk.sv
module mw_front_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_pin,
    input logic          org_x16,
    input logic          do_oe,
    input logic          cmd_valid,
    input logic [2:0]    cmd_kind,
    input logic [AW-1:0] cmd_addr
);
    logic [2:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 5) age_q <= age_q + 1'b1;
    end

    // R8
    cs_low_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 5 && !$past(cs_pin, 1) && !$past(cs_pin, 2) &&
         !$past(cs_pin, 3) && !$past(cs_pin, 4)) |-> !do_oe);

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R3
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_kind <= 3'd5));

    // R4
    x16_addr_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && org_x16) |-> ((cmd_addr >> (AW - 1)) == '0));

    // R7
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 5 && cmd_valid) |-> ($past(cs_pin, 3) || $past(cs_pin, 4)));
endmodule

bind mw_serial_front mw_front_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_pin    (cs_pin),
    .org_x16   (org_x16),
    .do_oe     (do_oe),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr)
);

// File: tb/sim_mw_serial_front.sv
`timescale 1ns/1ps
module sim_mw_serial_front;
    localparam int A16 = 6;
    localparam int AW  = A16 + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic org_x16 = 1'b1;
    logic cs_pin = 1'b0, sclk_pin = 1'b0, di_pin = 1'b0, ctl_busy = 1'b0;
    logic [15:0] mem_rdata;
    logic do_pin, do_oe, cmd_valid;
    logic [AW-1:0] mem_addr, cmd_addr;
    logic [2:0] cmd_kind;
    logic [15:0] cmd_data;

    int total = 0, bad = 0;
    int cmd_count = 0;
    logic [2:0]    last_kind;
    logic [AW-1:0] last_addr;
    logic [15:0]   last_data;
    bit finished = 0;

    always #4 clk = ~clk;

    function automatic logic [15:0] pattern(input logic [AW-1:0] a);
        logic [15:0] w;
        w = 16'(a) * 16'h9E37 + 16'h1234;
        return w ^ (16'(a) << 5);
    endfunction

    assign mem_rdata = pattern(mem_addr);

    mw_serial_front #(.A16(A16)) u0 (
        .clk(clk), .rst_n(rst_n), .org_x16(org_x16), .cs_pin(cs_pin),
        .sclk_pin(sclk_pin), .di_pin(di_pin), .ctl_busy(ctl_busy),
        .mem_rdata(mem_rdata), .do_pin(do_pin), .do_oe(do_oe),
        .mem_addr(mem_addr), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    always_ff @(posedge clk) begin
        if (cmd_valid) begin
            cmd_count <= cmd_count + 1;
            last_kind <= cmd_kind;
            last_addr <= cmd_addr;
            last_data <= cmd_data;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input logic b);
        di_pin = b;
        wait_n(3);
        sclk_pin = 1'b1;
        wait_n(5);
        sclk_pin = 1'b0;
        wait_n(4);
    endtask

    task automatic send(input int nb, input logic [31:0] v);
        for (int i = nb - 1; i >= 0; i--) tick(v[i]);
    endtask

    task automatic cs_off;
        cs_pin = 1'b0;
        di_pin = 1'b0;
        wait_n(6);
    endtask

    task automatic cs_on;
        cs_pin = 1'b1;
        wait_n(6);
    endtask

    function automatic int awid();
        return org_x16 ? A16 : AW;
    endfunction

    function automatic int dwid();
        return org_x16 ? 16 : 8;
    endfunction

    task automatic read_words(input string req, input logic [AW-1:0] a0, input int nw);
        logic [AW-1:0] a;
        logic [15:0] got, exp;
        a = a0;
        cs_on();
        tick(1'b1);
        send(2, 2'b10);
        send(awid(), 32'(a0));
        // R5: the dummy zero follows the last address bit
        check({req, " R5 dummy"}, {do_oe, do_pin}, 2'b10);
        for (int w = 0; w < nw; w++) begin
            got = '0;
            for (int b = 0; b < dwid(); b++) begin
                tick(1'b0);
                got = {got[14:0], do_pin};
            end
            exp = org_x16 ? pattern(a) : {8'h00, pattern(a)[7:0]};
            check(req, got, exp);
            a = org_x16 ? AW'((a + 1) % (1 << A16)) : AW'((a + 1) % (1 << AW));
        end
        cs_off();
        // R8
        check("R8 oe after read", do_oe, 1'b0);
    endtask

    task automatic expect_cmd(input string req, input int prev, input logic [2:0] k,
                              input logic [AW-1:0] a, input logic [15:0] d, input bit use_d);
        check({req, " count"}, cmd_count, prev + 1);
        check({req, " kind"}, last_kind, k);
        check({req, " addr"}, last_addr, a);
        if (use_d) check({req, " data"}, last_data, d);
    endtask

    initial begin
        int c0;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        // reset state
        check("R8 reset oe", do_oe, 1'b0);
        check("R7 reset strobe", cmd_count, 0);

        // R1: clocks with DI low and DI toggling are ignored
        cs_on();
        for (int i = 0; i < 5; i++) tick(1'b0);
        di_pin = 1'b1; wait_n(4); di_pin = 1'b0; wait_n(4);
        check("R1 no command", cmd_count, 0);
        check("R1 oe low", do_oe, 1'b0);
        cs_off();
        // clocks with CS low and DI high start nothing
        for (int i = 0; i < 4; i++) tick(1'b1);
        check("R1 cs low", {cmd_count[0], do_oe}, 2'b00);

        // R4 R2: full sweep of x16 reads (25 clocks each)
        org_x16 = 1'b1;
        for (int a = 0; a < (1 << A16); a++) read_words("R4 x16 read", AW'(a), 1);
        // R6: sequential with wrap, x16
        read_words("R6 x16 seq", AW'((1 << A16) - 2), 4);
        // R4: x8 reads, then R6 x8 wrap
        org_x16 = 1'b0;
        for (int a = 0; a < (1 << AW); a += 9) read_words("R4 x8 read", AW'(a), 1);
        read_words("R6 x8 seq", AW'((1 << AW) - 4), 8);

        // R2 write x16
        org_x16 = 1'b1;
        c0 = cmd_count;
        cs_on(); tick(1'b1); send(2, 2'b01); send(A16, 6'h15); send(16, 16'hA5C3); cs_off();
        expect_cmd("R2 write x16", c0, 3'd0, 7'h15, 16'hA5C3, 1);
        // R4 write x8
        org_x16 = 1'b0;
        c0 = cmd_count;
        cs_on(); tick(1'b1); send(2, 2'b01); send(AW, 7'h5A); send(8, 8'h3C); cs_off();
        expect_cmd("R4 write x8", c0, 3'd0, 7'h5A, 16'h003C, 1);
        // R2 erase x16, then R7 trailing clocks ignored
        org_x16 = 1'b1;
        c0 = cmd_count;
        cs_on(); tick(1'b1); send(2, 2'b11); send(A16, 6'h2F);
        for (int i = 0; i < 6; i++) tick(1'b1);
        check("R7 trailing oe", do_oe, 1'b0);
        cs_off();
        expect_cmd("R2 erase", c0, 3'd1, 7'h2F, 16'h0, 0);

        // R9 status after erase
        ctl_busy = 1'b1;
        cs_on();
        check("R9 busy", {do_oe, do_pin}, 2'b10);
        ctl_busy = 1'b0;
        wait_n(4);
        check("R9 ready", {do_oe, do_pin}, 2'b11);
        tick(1'b1);
        check("R9 cleared by start", do_oe, 1'b0);
        // the same frame continues: enable x16 (R3)
        c0 = cmd_count;
        send(2, 2'b00); send(A16, 6'h35); cs_off();
        expect_cmd("R3 enable", c0, 3'd4, 7'h35, 16'h0, 0);

        // R3 erase-all x8
        org_x16 = 1'b0;
        c0 = cmd_count;
        cs_on(); tick(1'b1); send(2, 2'b00); send(AW, 7'h43); cs_off();
        expect_cmd("R3 erase-all", c0, 3'd2, 7'h43, 16'h0, 0);
        // R3 write-all x16
        org_x16 = 1'b1;
        c0 = cmd_count;
        cs_on(); tick(1'b1); send(2, 2'b00); send(A16, 6'h1A); send(16, 16'h0F0F); cs_off();
        expect_cmd("R3 write-all", c0, 3'd3, 7'h1A, 16'h0F0F, 1);
        // R3 disable x8
        org_x16 = 1'b0;
        c0 = cmd_count;
        cs_on(); tick(1'b1); send(2, 2'b00); send(AW, 7'h1D); cs_off();
        expect_cmd("R3 disable", c0, 3'd5, 7'h1D, 16'h0, 0);

        // R7: frame cut short issues nothing
        org_x16 = 1'b1;
        c0 = cmd_count;
        cs_on(); tick(1'b1); send(2, 2'b01); send(A16, 6'h07); send(10, 10'h155); cs_off();
        wait_n(4);
        check("R7 cut frame", cmd_count, c0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule